// File: doc/BRIEF.md
# Eight-Channel Prescaled Pulse-Width Modulator

This block is a bank of pulse-width modulators reached over a small 16-bit register bus. Each channel divides the system clock by a programmable factor and counts over an 18-bit period. It drives its output active while the count is below an 18-bit compare value, and it can invert that output. Software writes the 18-bit values as a 16-bit low half and a 2-bit high half. Both halves land in shadow storage. The channel copies them into its working set only when a period finishes or when it leaves its stopped state, so it never runs on a half-updated value.

A single shared control word holds one stop bit per channel. While a channel's bit is 1, the channel is held: its counters sit at zero and its output rests at the inactive level for its polarity. Clearing the bit releases the channel, and it starts a fresh period on the next cycle. Each channel is a two-state machine. `CH_HELD` moves to `CH_RUN` (transition *release*) when its stop bit reads 0. `CH_RUN` moves back to `CH_HELD` (transition *halt*) when its stop bit reads 1. Inside `CH_RUN` the *wrap* event ends a period and reloads the working set.

Top module: `pwm_bank`

## Requirements
- R1: Channel n decodes the 128-byte window that starts at byte address n*0x80. The registers are 16 bits wide on a 4-byte stride. Within a window: 0x08 holds compare bits [15:0], 0x0C holds compare bits [17:16] in its bits [1:0], 0x10 holds period bits [15:0], 0x14 holds period bits [17:16] in its bits [1:0], 0x18 holds the divider code in bits [7:0], and bit 4 of 0x1C is the polarity.
- R2: After system reset, the stop word at address 0x1FC reads with every channel bit set, every configuration register reads zero, and every output is low.
- R3: The low and high registers combine into one 18-bit value. A high register keeps and returns only its two bits.
- R4: While running with divider code 0, the output is active during the first D cycles of every P-cycle period, where D is the compare value and P the period. A compare value of P or more gives a constant active level. A compare value of 0 gives a constant inactive level.
- R5: A divider code K makes every count step last K+1 clock cycles.
- R6: Polarity 1 inverts the output. The change takes effect at once.
- R7: While a channel's stop bit is 1, its counter and divider stay at zero and its output equals its polarity bit, which is the inactive level.
- R8: Clearing a stop bit loads the shadow values, and the first period starts from count zero on the following cycle.
- R9: Writes to the period, compare or divider registers of a running channel take effect only at the end of the current period.
- R10: Bit i of the stop word at 0x1FC controls only channel i. The other channels keep running unchanged.
- R11: Reads return the shadow values last written. Offsets that are not mapped read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 10 | Byte address, word aligned |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pwm_o | output | 8 | One modulated output per channel |

## Verification
The bench measures the lengths of the high run and the low run between rising edges. A period of 4 with compare 1 is run at divider codes 0 and 2: a 1/3 split against a 3/9 split shows that the prescaler stretches each count step. Inverting the polarity on a running channel swaps the two run lengths, which separates the polarity path from the compare. A compare change written just after a rising edge must leave that period at its old length and shorten only the next one, which exposes any immediate load. A compare placed only in the high bits, with a short period, must give a constant high where a dropped high half would give a constant low. Stopping one channel while watching another shows that the stop bits are independent.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int CNT_W = 18;
    localparam int PRE_W = 8;
    localparam int HI_W  = CNT_W - 16;
    localparam int OFF_W = 7;

    localparam logic [OFF_W-1:0] OFF_CMP_LO = 7'h08;
    localparam logic [OFF_W-1:0] OFF_CMP_HI = 7'h0C;
    localparam logic [OFF_W-1:0] OFF_PER_LO = 7'h10;
    localparam logic [OFF_W-1:0] OFF_PER_HI = 7'h14;
    localparam logic [OFF_W-1:0] OFF_DIV    = 7'h18;
    localparam logic [OFF_W-1:0] OFF_CTL    = 7'h1C;
    localparam int               POL_BIT    = 4;
    localparam int               STOP_ADDR  = 'h1FC;

    typedef enum logic [0:0] {
        CH_HELD = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] cmp;
        logic [PRE_W-1:0] div;
    } ch_cfg_t;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output ch_cfg_t           cfg_o [NUM_CH],
    output logic [NUM_CH-1:0] pol_o,
    output logic [NUM_CH-1:0] stop_o
);

    localparam int SEL_W = ADDR_W - OFF_W;

    logic [SEL_W-1:0] ch_sel;
    logic [OFF_W-1:0] off;
    logic             stop_hit;

    logic [15:0]      cmp_lo [NUM_CH];
    logic [HI_W-1:0]  cmp_hi [NUM_CH];
    logic [15:0]      per_lo [NUM_CH];
    logic [HI_W-1:0]  per_hi [NUM_CH];
    logic [PRE_W-1:0] div_q  [NUM_CH];

    assign ch_sel   = addr[ADDR_W-1:OFF_W];
    assign off      = addr[OFF_W-1:0];
    assign stop_hit = (addr == ADDR_W'(STOP_ADDR));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_o <= '1;
        end else if (wr_en && stop_hit) begin
            stop_o <= wdata[NUM_CH-1:0];
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_shadow
        logic ch_wr;
        assign ch_wr = wr_en && !stop_hit && (ch_sel == SEL_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_lo[i] <= '0;
                cmp_hi[i] <= '0;
                per_lo[i] <= '0;
                per_hi[i] <= '0;
                div_q[i]  <= '0;
                pol_o[i]  <= 1'b0;
            end else if (ch_wr) begin
                case (off)
                    OFF_CMP_LO: cmp_lo[i] <= wdata;
                    OFF_CMP_HI: cmp_hi[i] <= wdata[HI_W-1:0];
                    OFF_PER_LO: per_lo[i] <= wdata;
                    OFF_PER_HI: per_hi[i] <= wdata[HI_W-1:0];
                    OFF_DIV:    div_q[i]  <= wdata[PRE_W-1:0];
                    OFF_CTL:    pol_o[i]  <= wdata[POL_BIT];
                    default: ;
                endcase
            end
        end

        assign cfg_o[i].period = {per_hi[i], per_lo[i]};
        assign cfg_o[i].cmp    = {cmp_hi[i], cmp_lo[i]};
        assign cfg_o[i].div    = div_q[i];
    end

    always_comb begin
        rdata = '0;
        if (stop_hit) begin
            rdata = 16'(stop_o);
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (ch_sel == SEL_W'(i)) begin
                    case (off)
                        OFF_CMP_LO: rdata = cmp_lo[i];
                        OFF_CMP_HI: rdata = 16'(cmp_hi[i]);
                        OFF_PER_LO: rdata = per_lo[i];
                        OFF_PER_HI: rdata = 16'(per_hi[i]);
                        OFF_DIV:    rdata = 16'(div_q[i]);
                        OFF_CTL:    rdata = 16'(pol_o[i]) << POL_BIT;
                        default:    rdata = '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_bank_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    stop_i,
    input  logic    pol_i,
    input  ch_cfg_t cfg_i,
    output logic    pwm_o,
    output logic    idle_o
);

    ch_state_e        state_q, state_d;
    ch_cfg_t          act_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;
    logic             step;
    logic             wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_HELD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_HELD: if (!stop_i) state_d = CH_RUN;
            CH_RUN:  if (stop_i)  state_d = CH_HELD;
            default: state_d = CH_HELD;
        endcase
    end

    assign step = (pre_q == act_q.div);
    assign wrap = step && (({1'b0, cnt_q} + 1'b1) >= {1'b0, act_q.period});

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            pre_q <= '0;
            act_q <= '0;
        end else if (stop_i || state_q == CH_HELD) begin
            cnt_q <= '0;
            pre_q <= '0;
            act_q <= cfg_i;
        end else begin
            pre_q <= step ? '0 : pre_q + 1'b1;
            if (wrap) begin
                cnt_q <= '0;
                act_q <= cfg_i;
            end else if (step) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        pwm_o  = ((state_q == CH_RUN) && (cnt_q < act_q.cmp)) ^ pol_i;
        idle_o = (cnt_q == '0) && (pre_q == '0);
    end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic [NUM_CH-1:0] pwm_o
);

    ch_cfg_t           cfg [NUM_CH];
    logic [NUM_CH-1:0] pol_vec;
    logic [NUM_CH-1:0] stop_vec;
    logic [NUM_CH-1:0] idle_vec;

    pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .cfg_o  (cfg),
        .pol_o  (pol_vec),
        .stop_o (stop_vec)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pwm_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .stop_i (stop_vec[i]),
            .pol_i  (pol_vec[i]),
            .cfg_i  (cfg[i]),
            .pwm_o  (pwm_o[i]),
            .idle_o (idle_vec[i])
        );
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_bank_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       wdata,
    input logic [15:0]       rdata,
    input logic [NUM_CH-1:0] pwm_o,
    input logic [NUM_CH-1:0] pol_vec,
    input logic [NUM_CH-1:0] stop_vec,
    input logic [NUM_CH-1:0] idle_vec
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        // R7
        held_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_vec[i] && $past(stop_vec[i])) |-> (pwm_o[i] == pol_vec[i]));

        // R7
        held_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_vec[i] && $past(stop_vec[i])) |-> idle_vec[i]);
    end

    // R10
    stop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(STOP_ADDR)) |=> (stop_vec == $past(wdata[NUM_CH-1:0])));

    // R11
    stop_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(STOP_ADDR)) |-> (rdata == 16'(stop_vec)));

endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .pwm_o    (pwm_o),
    .pol_vec  (pol_vec),
    .stop_vec (stop_vec),
    .idle_vec (idle_vec)
);

// File: tb/test_pwm_bank.sv
module test_pwm_bank;

    localparam int NCH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [7:0]  pwm_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    pwm_bank #(.NUM_CH(NCH), .ADDR_W(10)) i_pwm_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_o(pwm_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [9:0] ra(input int ch, input int off);
        return 10'(ch * 128 + off);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output int v);
        @(negedge clk);
        addr = a;
        #1 v = int'(rdata);
    endtask

    task automatic cfg(input int ch, input int per, input int cmp, input int dv);
        wr(ra(ch, 'h10), 16'(per)); wr(ra(ch, 'h14), 16'(per >> 16));
        wr(ra(ch, 'h08), 16'(cmp)); wr(ra(ch, 'h0C), 16'(cmp >> 16));
        wr(ra(ch, 'h18), 16'(dv));
    endtask

    // Waits for a rising edge on channel ch, then measures the high and low runs.
    // When do_wr is set, one bus write is issued in the first high cycle.
    task automatic runs(input int ch, output int hi, output int lo,
                        input bit do_wr, input logic [9:0] a, input logic [15:0] d);
        logic prev;
        @(negedge clk); prev = pwm_o[ch];
        forever begin
            @(negedge clk);
            if (!prev && pwm_o[ch]) break;
            prev = pwm_o[ch];
        end
        hi = 1; lo = 0;
        if (do_wr) begin wr_en = 1'b1; addr = a; wdata = d; end
        @(negedge clk);
        wr_en = 1'b0;
        while (pwm_o[ch]) begin hi++; @(negedge clk); end
        while (!pwm_o[ch]) begin lo++; @(negedge clk); end
    endtask

    task automatic steady(input string req, input int ch, input int lvl, input int n);
        int diff = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (int'(pwm_o[ch]) != lvl) diff++;
        end
        check(req, diff, 0);
    endtask

    task automatic t_reset;
        int v;
        rd(10'h1FC, v); check("R2 stop word", v, 'hFF);
        rd(ra(0, 'h10), v); check("R2 period zero", v, 0);
        check("R2 outputs low", int'(pwm_o), 0);
    endtask

    task automatic t_held_and_read;
        int v;
        cfg(0, 4, 1, 0);
        steady("R7 held inactive", 0, 0, 12);
        rd(ra(0, 'h10), v); check("R11 period readback", v, 4);
        rd(ra(0, 'h08), v); check("R1 compare at 0x08", v, 1);
        wr(ra(0, 'h0C), 16'hFFFF);
        rd(ra(0, 'h0C), v); check("R3 high half two bits", v, 3);
        wr(ra(0, 'h0C), 16'h0000);
        rd(ra(7, 'h00), v); check("R11 unmapped zero", v, 0);
    endtask

    task automatic t_release;
        int hi, lo;
        wr(10'h1FC, 16'h00FE);
        runs(0, hi, lo, 1'b0, '0, '0);
        check("R4 high run", hi, 1); check("R8 R4 low run", lo, 3);
    endtask

    task automatic t_prescale;
        int hi, lo;
        cfg(1, 4, 1, 2);
        wr(10'h1FC, 16'h00FC);
        runs(1, hi, lo, 1'b0, '0, '0);
        check("R5 high run x3", hi, 3); check("R5 low run x3", lo, 9);
    endtask

    task automatic t_polarity;
        int hi, lo;
        wr(ra(1, 'h1C), 16'h0010);
        runs(1, hi, lo, 1'b0, '0, '0);
        check("R6 inverted high", hi, 9); check("R6 inverted low", lo, 3);
    endtask

    task automatic t_deferred;
        int hi, lo;
        cfg(0, 10, 5, 0);
        repeat (30) @(negedge clk);
        runs(0, hi, lo, 1'b0, '0, '0);
        check("R9 base high", hi, 5);
        runs(0, hi, lo, 1'b1, ra(0, 'h08), 16'd2);
        check("R9 current period kept", hi, 5);
        runs(0, hi, lo, 1'b0, '0, '0);
        check("R9 next period high", hi, 2); check("R9 next period low", lo, 8);
    endtask

    task automatic t_wide;
        cfg(2, 4, 'h10000, 0);
        wr(10'h1FC, 16'h00F8);
        steady("R3 R4 compare above period", 2, 1, 16);
        wr(ra(2, 'h0C), 16'h0000);
        repeat (8) @(negedge clk);
        steady("R4 compare zero", 2, 0, 16);
    endtask

    task automatic t_independent;
        int hi, lo;
        wr(10'h1FC, 16'h00F9);
        repeat (2) @(negedge clk);
        steady("R7 stopped again", 0, 0, 16);
        runs(1, hi, lo, 1'b0, '0, '0);
        check("R10 neighbour high", hi, 9); check("R10 neighbour low", lo, 3);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_held_and_read();
        t_release();
        t_prescale();
        t_polarity();
        t_deferred();
        t_wide();
        t_independent();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule